// File: doc/BRIEF.md
# Dual-Bank Segment Display RAM Controller

This block is the display memory of a segment LCD driver. It takes bytes that an upstream serial host interface has already framed, each tagged with a register-select flag from the control byte. When the flag is 0 the byte is a command. The only command decoded here is the bank-select command, which picks a write bank and a display bank independently. When the flag is 1 the byte is display data. It is stored at a write pointer that advances by itself after each byte. A separate pointer-load input sets the pointer.

The memory holds two equal banks. In the banked drive modes, the host fills one bank while the panel refresh sequencer reads the other through its own registered read port. In the eight-way multiplex mode the bank selects have no effect, and both banks form one flat display area for writing and for reading. A write and a read may happen in the same cycle. The array is never cleared by reset, so the host must write zeros itself after power-up. `BANK_DEPTH` must be a power of two.

Top module: `segram_bank_ctrl`

## Requirements
- R1: After reset, `write_bank` and `disp_bank` are both 0.
- R2: A byte with `host_valid`=1 and `host_rs`=0 whose bits 7..2 are `000010` is a bank-select command. From the next clock edge, `write_bank` equals its bit 1 and `disp_bank` equals its bit 0. Both selects are stored in every mode.
- R3: Command bytes with other bits 7..2, and data bytes (`host_rs`=1) of any value, leave `write_bank` and `disp_bank` unchanged.
- R4: With `host_valid`=1 and `host_rs`=1, the byte is stored whole. Any value from 0x00 to 0xFF is accepted. In banked mode (`mode_1to8`=0) it goes to pointer offset `ptr[AW-1:0]` of the bank named by `write_bank`.
- R5: Each stored byte advances the pointer by one. In banked mode the pointer wraps from BANK_DEPTH-1 to 0 and stays inside the bank.
- R6: `ptr_load` sets the pointer to `ptr_value`. In banked mode only its low AW bits are used. A data byte in the same cycle is stored at the old pointer, and the load wins over the advance.
- R7: `rd_data` shows, one cycle after `rd_addr`, the byte at offset `rd_addr[AW-1:0]` of the bank named by `disp_bank`.
- R8: With `mode_1to8`=1, the selects are ignored. Writes use the full pointer over 2*BANK_DEPTH locations and wrap from 2*BANK_DEPTH-1 to 0. Reads use the full `rd_addr`. Flat address a equals bank a/BANK_DEPTH, offset a mod BANK_DEPTH.
- R9: A write and a read in the same cycle both complete. A read of the location being written returns its previous content, and the new byte is visible one cycle later.
- R10: A data byte that directly follows a bank-select command is stored in the newly selected write bank.
- R11: Reset clears the selects and the pointer but leaves the stored bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_1to8 | input | 1 | 1 = eight-way multiplex, flat memory; 0 = banked modes |
| host_valid | input | 1 | A host byte is present this cycle |
| host_rs | input | 1 | Register-select flag: 1 = data, 0 = command |
| host_byte | input | 8 | Host byte |
| ptr_load | input | 1 | Load the write pointer |
| ptr_value | input | AW+1 | Value for the write pointer |
| rd_addr | input | AW+1 | Refresh read address |
| rd_data | output | 8 | Refresh read data, one cycle after `rd_addr` |
| write_bank | output | 1 | Current write bank select |
| disp_bank | output | 1 | Current display bank select |

## Verification
A host data write and a refresh read can fall in the same clock cycle. The bench provokes this by presenting a data byte and a read address in one cycle, aimed at both the same location and different locations. Its scoreboard expects the old byte from the read, and then expects the new byte from a read in the next cycle. The bench also sends a bank-select command and a data byte back to back. It judges them by reading the target offset from both banks afterwards.

// File: rtl/segram_pkg.sv
package segram_pkg;

    // Opcode carried in bits 7..2 of a bank-select command byte
    localparam logic [5:0] BANKSEL_OPC = 6'b000010;

    typedef struct packed {
        logic wbank;
        logic dbank;
    } bank_sel_t;

endpackage

// File: rtl/segram_cmd_decode.sv
module segram_cmd_decode
    import segram_pkg::*;
(
    input  logic       host_valid,
    input  logic       host_rs,
    input  logic [7:0] host_byte,
    output logic       is_banksel,
    output logic       is_data,
    output bank_sel_t  new_sel
);
    always_comb begin
        is_data       = host_valid && host_rs;
        is_banksel    = host_valid && !host_rs && (host_byte[7:2] == BANKSEL_OPC);
        new_sel.wbank = host_byte[1];
        new_sel.dbank = host_byte[0];
    end
endmodule

// File: rtl/segram_ptr_gen.sv
module segram_ptr_gen #(
    parameter int BANK_DEPTH = 16,
    localparam int AW  = $clog2(BANK_DEPTH),
    localparam int FAW = AW + 1
) (
    input  logic           mode_1to8,
    input  logic           step,
    input  logic           load,
    input  logic [FAW-1:0] load_val,
    input  logic [FAW-1:0] ptr_q,
    output logic [FAW-1:0] ptr_d
);
    localparam logic [FAW-1:0] LAST_BANKED = FAW'(BANK_DEPTH - 1);
    localparam logic [FAW-1:0] LAST_FLAT   = FAW'(2 * BANK_DEPTH - 1);

    logic [FAW-1:0] low_q;

    always_comb begin
        low_q = {1'b0, ptr_q[AW-1:0]};
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = mode_1to8 ? load_val : {1'b0, load_val[AW-1:0]};
        end else if (step) begin
            if (mode_1to8) begin
                ptr_d = (ptr_q == LAST_FLAT) ? '0 : ptr_q + 1'b1;
            end else begin
                ptr_d = (low_q == LAST_BANKED) ? '0 : low_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/segram_addr_map.sv
module segram_addr_map #(
    parameter int BANK_DEPTH = 16,
    localparam int AW  = $clog2(BANK_DEPTH),
    localparam int FAW = AW + 1
) (
    input  logic           mode_1to8,
    input  logic           bank,
    input  logic [FAW-1:0] addr,
    output logic [FAW-1:0] phys
);
    always_comb begin
        phys = mode_1to8 ? addr : {bank, addr[AW-1:0]};
    end
endmodule

// File: rtl/segram_mem.sv
module segram_mem #(
    parameter int BANK_DEPTH = 16,
    localparam int AW    = $clog2(BANK_DEPTH),
    localparam int FAW   = AW + 1,
    localparam int TOTAL = 2 * BANK_DEPTH
) (
    input  logic           clk,
    input  logic           we,
    input  logic [FAW-1:0] waddr,
    input  logic [7:0]     wdata,
    input  logic [FAW-1:0] raddr,
    output logic [7:0]     rdata
);
    // No reset on purpose: the contents are undefined until the host writes them
    logic [7:0] arr [TOTAL];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            arr[waddr] <= wdata;
        end
        rdata_q <= arr[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/segram_bank_ctrl.sv
module segram_bank_ctrl
    import segram_pkg::*;
#(
    parameter int BANK_DEPTH = 16,
    localparam int AW  = $clog2(BANK_DEPTH),
    localparam int FAW = AW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_1to8,
    input  logic           host_valid,
    input  logic           host_rs,
    input  logic [7:0]     host_byte,
    input  logic           ptr_load,
    input  logic [FAW-1:0] ptr_value,
    input  logic [FAW-1:0] rd_addr,
    output logic [7:0]     rd_data,
    output logic           write_bank,
    output logic           disp_bank
);
    typedef struct packed {
        bank_sel_t      sel;
        logic [FAW-1:0] ptr;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic           is_banksel;
    logic           wr_en;
    bank_sel_t      cmd_sel;
    logic [FAW-1:0] ptr_next;
    logic [FAW-1:0] cur_ptr;
    logic [FAW-1:0] wr_phys;
    logic [FAW-1:0] rd_phys;

    segram_cmd_decode u_dec (
        .host_valid (host_valid),
        .host_rs    (host_rs),
        .host_byte  (host_byte),
        .is_banksel (is_banksel),
        .is_data    (wr_en),
        .new_sel    (cmd_sel)
    );

    segram_ptr_gen #(.BANK_DEPTH(BANK_DEPTH)) u_ptr (
        .mode_1to8 (mode_1to8),
        .step      (wr_en),
        .load      (ptr_load),
        .load_val  (ptr_value),
        .ptr_q     (st_q.ptr),
        .ptr_d     (ptr_next)
    );

    // The write side uses the registered selects, so a new bank applies from the next byte
    segram_addr_map #(.BANK_DEPTH(BANK_DEPTH)) u_wmap (
        .mode_1to8 (mode_1to8),
        .bank      (st_q.sel.wbank),
        .addr      (st_q.ptr),
        .phys      (wr_phys)
    );

    segram_addr_map #(.BANK_DEPTH(BANK_DEPTH)) u_rmap (
        .mode_1to8 (mode_1to8),
        .bank      (st_q.sel.dbank),
        .addr      (rd_addr),
        .phys      (rd_phys)
    );

    segram_mem #(.BANK_DEPTH(BANK_DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_phys),
        .wdata (host_byte),
        .raddr (rd_phys),
        .rdata (rd_data)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ptr = ptr_next;
        if (is_banksel) begin
            st_d.sel = cmd_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_ptr    = st_q.ptr;
    assign write_bank = st_q.sel.wbank;
    assign disp_bank  = st_q.sel.dbank;
endmodule

// File: rtl/segram_bank_ctrl_chk.sv
module segram_bank_ctrl_chk #(
    parameter int BANK_DEPTH = 16,
    localparam int AW  = $clog2(BANK_DEPTH),
    localparam int FAW = AW + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mode_1to8,
    input logic           host_valid,
    input logic           host_rs,
    input logic [7:0]     host_byte,
    input logic           ptr_load,
    input logic [FAW-1:0] ptr_value,
    input logic           write_bank,
    input logic           disp_bank,
    input logic [FAW-1:0] cur_ptr,
    input logic           wr_en,
    input logic [FAW-1:0] wr_phys
);
    localparam logic [FAW-1:0] LAST_BANKED = FAW'(BANK_DEPTH - 1);

    logic cmd_hit;
    logic [FAW-1:0] low_ptr;
    assign cmd_hit = host_valid && !host_rs && (host_byte[7:2] == 6'b000010);
    assign low_ptr = {1'b0, cur_ptr[AW-1:0]};

    assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hit |=> (write_bank == $past(host_byte[1])) && (disp_bank == $past(host_byte[0])));

    assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_hit |=> $stable(write_bank) && $stable(disp_bank));

    assert_write_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_1to8) |-> (wr_phys[AW] == write_bank) && (wr_phys[AW-1:0] == cur_ptr[AW-1:0]));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_load && !mode_1to8 && low_ptr != LAST_BANKED) |=> cur_ptr == $past(low_ptr) + 1'b1);

    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_load && !mode_1to8 && low_ptr == LAST_BANKED) |=> cur_ptr == '0);

    assert_ptr_load_flat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load && mode_1to8) |=> cur_ptr == $past(ptr_value));

    assert_ptr_load_banked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load && !mode_1to8) |=> cur_ptr == {1'b0, $past(ptr_value[AW-1:0])});

    assert_flat_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_1to8) |-> wr_phys == cur_ptr);

    assert_next_byte_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_1to8 && $past(cmd_hit)) |-> wr_phys[AW] == $past(host_byte[1]));
endmodule

bind segram_bank_ctrl segram_bank_ctrl_chk #(.BANK_DEPTH(BANK_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_1to8  (mode_1to8),
    .host_valid (host_valid),
    .host_rs    (host_rs),
    .host_byte  (host_byte),
    .ptr_load   (ptr_load),
    .ptr_value  (ptr_value),
    .write_bank (write_bank),
    .disp_bank  (disp_bank),
    .cur_ptr    (cur_ptr),
    .wr_en      (wr_en),
    .wr_phys    (wr_phys)
);

// File: tb/segram_bank_ctrl_tb.sv
module segram_bank_ctrl_tb;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int FAW   = AW + 1;
    localparam int TOTAL = 2 * DEPTH;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mode_1to8 = 1'b0;
    logic           host_valid = 1'b0;
    logic           host_rs = 1'b0;
    logic [7:0]     host_byte = '0;
    logic           ptr_load = 1'b0;
    logic [FAW-1:0] ptr_value = '0;
    logic [FAW-1:0] rd_addr = '0;
    logic [7:0]     rd_data;
    logic           write_bank;
    logic           disp_bank;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit rd_pend = 0;

    // reference model built from the requirements
    logic [7:0] ref_mem [TOTAL];
    int m_wb = 0, m_db = 0, m_ptr = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    segram_bank_ctrl #(.BANK_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_1to8(mode_1to8),
        .host_valid(host_valid), .host_rs(host_rs), .host_byte(host_byte),
        .ptr_load(ptr_load), .ptr_value(ptr_value),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .write_bank(write_bank), .disp_bank(disp_bank)
    );

    function automatic int wphys();
        return mode_1to8 ? m_ptr : (m_wb * DEPTH + (m_ptr % DEPTH));
    endfunction

    function automatic int rphys(input int a);
        return mode_1to8 ? a : (m_db * DEPTH + (a % DEPTH));
    endfunction

    function automatic void advance();
        if (mode_1to8) m_ptr = (m_ptr == TOTAL - 1) ? 0 : m_ptr + 1;
        else           m_ptr = ((m_ptr % DEPTH) == DEPTH - 1) ? 0 : (m_ptr % DEPTH) + 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_drv();
        host_valid = 0; host_rs = 0; ptr_load = 0; rd_pend = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            clear_drv();
        end
    endtask

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk);
        clear_drv();
        host_valid = 1; host_rs = 0; host_byte = b;
        if (b[7:2] == 6'b000010) begin
            m_wb = b[1]; m_db = b[0];
        end
    endtask

    task automatic send_data(input logic [7:0] b);
        @(negedge clk);
        clear_drv();
        host_valid = 1; host_rs = 1; host_byte = b;
        ref_mem[wphys()] = b;
        advance();
    endtask

    task automatic load_ptr(input int v);
        @(negedge clk);
        clear_drv();
        ptr_load = 1; ptr_value = FAW'(v);
        m_ptr = mode_1to8 ? v : v % DEPTH;
    endtask

    // data byte and pointer load in one cycle
    task automatic data_with_load(input logic [7:0] b, input int v);
        @(negedge clk);
        clear_drv();
        host_valid = 1; host_rs = 1; host_byte = b;
        ptr_load = 1; ptr_value = FAW'(v);
        ref_mem[wphys()] = b;
        m_ptr = mode_1to8 ? v : v % DEPTH;
    endtask

    task automatic do_read(input int a, input string tag);
        @(negedge clk);
        clear_drv();
        rd_addr = FAW'(a); rd_pend = 1;
        exp_q.push_back(ref_mem[rphys(a)]);
        tag_q.push_back(tag);
    endtask

    // data write and refresh read in one cycle; read expects the old content
    task automatic data_and_read(input logic [7:0] b, input int a, input string tag);
        @(negedge clk);
        clear_drv();
        rd_addr = FAW'(a); rd_pend = 1;
        exp_q.push_back(ref_mem[rphys(a)]);
        tag_q.push_back(tag);
        host_valid = 1; host_rs = 1; host_byte = b;
        ref_mem[wphys()] = b;
        advance();
    endtask

    // monitor: pops one expected item per issued read
    always @(posedge clk) begin
        bit pend_now;
        pend_now = rd_pend;
        #2;
        if (pend_now) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R7 actual=%0h expected=queued-item", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(rd_data), int'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < TOTAL; i++) ref_mem[i] = 8'h00;
        idle(3);
        @(negedge clk); rst_n = 1;
        // R1: reset state
        check("R1 write_bank", int'(write_bank), 0);
        check("R1 disp_bank",  int'(disp_bank), 0);

        // clear the whole array through the flat mode
        @(negedge clk); mode_1to8 = 1;
        load_ptr(0);
        for (int i = 0; i < TOTAL; i++) send_data(8'h00);
        idle(1);
        @(negedge clk); mode_1to8 = 0; m_ptr = m_ptr % DEPTH;

        // R4 / R7: full-range byte values in bank 0
        load_ptr(3);
        send_data(8'hA5); send_data(8'h00); send_data(8'hFF);
        do_read(3, "R4 R7 bank0 off3");
        do_read(4, "R4 R7 bank0 off4");
        do_read(5, "R4 R7 bank0 off5");
        idle(2);

        // R2 / R10: bank select directly followed by data
        send_cmd(8'h0A);
        send_data(8'h3C);
        idle(1);
        check("R2 write_bank", int'(write_bank), 1);
        check("R2 disp_bank",  int'(disp_bank), 0);
        do_read(6, "R10 bank0 untouched");
        send_cmd(8'h09);
        idle(1);
        check("R2 write_bank after 09", int'(write_bank), 0);
        check("R2 disp_bank after 09",  int'(disp_bank), 1);
        do_read(6, "R10 bank1 got byte");
        idle(2);

        // R3: other command and data with the opcode pattern change nothing
        send_cmd(8'h4A);
        send_cmd(8'h0B ^ 8'h80);
        @(negedge clk);
        clear_drv();
        host_valid = 1; host_rs = 1; host_byte = 8'h0A;
        ref_mem[wphys()] = 8'h0A; advance();
        idle(1);
        check("R3 write_bank", int'(write_bank), 0);
        check("R3 disp_bank",  int'(disp_bank), 1);

        // R5: wrap inside bank 0
        load_ptr(14);
        send_data(8'h11); send_data(8'h22); send_data(8'h33);
        send_cmd(8'h08);
        do_read(0,  "R5 wrapped to off0");
        do_read(15, "R5 last offset");
        do_read(14, "R5 first offset");
        send_cmd(8'h09);
        do_read(0, "R5 bank1 off0 untouched");
        idle(2);

        // R6: load in the same cycle as a data byte
        send_cmd(8'h00 | 8'h08);
        load_ptr(9);
        data_with_load(8'h5A, 12);
        send_data(8'h6B);
        do_read(9,  "R6 byte at old pointer");
        do_read(12, "R6 next byte at loaded pointer");
        do_read(10, "R6 no advance past old pointer");
        idle(2);

        // R9: same-cycle write and read
        load_ptr(7);
        data_and_read(8'hC3, 7, "R9 read old same location");
        do_read(7, "R9 new byte visible");
        data_and_read(8'hD4, 3, "R9 read other location");
        do_read(8, "R9 write completed");
        idle(2);

        // R8: flat mode ignores selects
        send_cmd(8'h0A);
        @(negedge clk); clear_drv(); mode_1to8 = 1;
        load_ptr(17);
        send_data(8'h77);
        load_ptr(31);
        send_data(8'h88); send_data(8'h99);
        do_read(17, "R8 flat 17");
        do_read(31, "R8 flat 31");
        do_read(0,  "R8 flat wrap 0");
        idle(1);
        @(negedge clk); mode_1to8 = 0;
        send_cmd(8'h09);
        do_read(1, "R8 flat 17 is bank1 off1");
        idle(2);

        // R11: reset keeps the array
        @(negedge clk); clear_drv(); rst_n = 0;
        m_wb = 0; m_db = 0; m_ptr = 0;
        idle(2);
        @(negedge clk); rst_n = 1;
        check("R1 R11 write_bank after reset", int'(write_bank), 0);
        check("R1 R11 disp_bank after reset",  int'(disp_bank), 0);
        do_read(0, "R11 bank0 off0 kept");
        do_read(3, "R11 bank0 off3 kept");
        idle(3);

        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R7 actual=%0d expected=0 pending reads", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule